// File: doc/BRIEF.md
# Bus Target Address Claim Decoder

This block sits on the target side of a shared, multiplexed address/data bus that uses an active-low framing strobe. On the first clock edge where the framing strobe is seen low while the bus is idle, it captures the address, the command nibble, the slot-select line and the claim-speed setting. The address and command are only on the bus for that one clock, so every later decision uses the captured copy.

The block then decodes the captured address and command against three windows. The memory window is a 64-bit base with a mask. The I/O window is a 32-bit base with a mask. The configuration space needs no window: it is selected by the slot-select line. When the address hits a window of the matching class, the block drives its active-low claim output after a selectable delay. It also reports a hit flag, the decoded space type and the offset inside the window.

When 64-bit support is built in, a two-cycle address command is accepted. The low address half comes on the first clock, and the high half with the real command on the second. Without 64-bit support, such cycles are never claimed. The data-ready and stop outputs stay deasserted, because data transfer belongs to another block.

Top module: `tgt_claim_decoder`

## Requirements
- R1: Address, command, slot-select and speed setting are captured on the first rising edge where `frame_n` is low after the bus was idle. Changes on these inputs after that edge do not alter the decision for that transaction.
- R2: Counted from the final address edge, `devsel_n` goes low at the 1st edge for `speed_mode` 00 (fast), the 2nd edge for 01 (medium) and the 3rd edge for 10 (slow). The encoding 11 behaves as slow.
- R3: `trdy_n` and `stop_n` are high at all times, including while a cycle is being decoded or claimed.
- R4: Command 1010 or 1011 (configuration) is claimed only when `idsel` was high at the address edge, and the upper address bits are ignored. `space` reads 3 and `reg_offset` equals the address bits [OFF_W-1:0].
- R5: Commands 0110, 0111, 1100, 1110 and 1111 (memory) are claimed when `((addr ^ mem_base) & mem_mask) == 0` over 64 bits, where a single-cycle address has a zero upper half. `space` reads 1 and `reg_offset` is the address AND NOT `mem_mask`, truncated to OFF_W bits.
- R6: Commands 0010 and 0011 (I/O) are claimed when `((addr ^ io_base) & io_mask) == 0` over 32 bits. `space` reads 2 and `reg_offset` is the address AND NOT `io_mask`, truncated.
- R7: A hit requires the command class to match the window type. Any other command (for example 0000) is never claimed.
- R8: Command 1101 (dual address) with SUPPORT_64=1 takes the high address half and the real command on the next edge, and timing counts from that second edge. Only memory commands can then be claimed. With SUPPORT_64=0 a dual-address cycle is never claimed.
- R9: Once asserted, `devsel_n` stays low until `frame_n` and `irdy_n` are both sampled high. It goes high, and `hit` goes low, at that edge. An unclaimed transaction is not re-decoded while `frame_n` stays low.
- R10: Reset (asynchronous, active low) forces `devsel_n` high, `hit` low and `space` to 0, even in the middle of a claim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low transaction framing strobe |
| irdy_n | input | 1 | Active-low initiator-ready strobe |
| ad | input | AD_W | Multiplexed address/data lines |
| cbe_n | input | 4 | Command nibble during address clocks |
| idsel | input | 1 | Slot select for configuration cycles |
| speed_mode | input | 2 | Claim speed: 00 fast, 01 medium, 10/11 slow |
| mem_base | input | 2*AD_W | Memory window base |
| mem_mask | input | 2*AD_W | Memory window compare mask (1 = compared) |
| io_base | input | AD_W | I/O window base |
| io_mask | input | AD_W | I/O window compare mask (1 = compared) |
| devsel_n | output | 1 | Active-low claim |
| trdy_n | output | 1 | Target ready, held high |
| stop_n | output | 1 | Target stop, held high |
| hit | output | 1 | Cycle decoded as ours |
| space | output | 2 | 0 none, 1 memory, 2 I/O, 3 configuration |
| reg_offset | output | OFF_W | Offset within the decoded window |

## Verification
The hardest state to reach is a transaction that was decoded as a miss while the bus stays busy. If the address lines later carry a valid hit address and command while `frame_n` is still low, the block must not claim. The bench reaches this state by starting an unclaimed memory read and holding `frame_n` low. It then drives a matching address and memory command for several clocks and watches `devsel_n` stay high. Dual-address cycles are run against a second instance built without 64-bit support, so that the claiming and non-claiming variants see the same bus traffic.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

   typedef enum logic [1:0] {
      SP_NONE = 2'd0,
      SP_MEM  = 2'd1,
      SP_IO   = 2'd2,
      SP_CFG  = 2'd3
   } space_e;

   localparam logic [3:0] CMD_IO_RD   = 4'b0010;
   localparam logic [3:0] CMD_IO_WR   = 4'b0011;
   localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
   localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
   localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
   localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
   localparam logic [3:0] CMD_DUAL    = 4'b1101;
   localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
   localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

   // Map a command nibble onto the window class it may hit.
   function automatic space_e cmd_space(input logic [3:0] c);
      case (c)
         CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM,
         CMD_MEM_RDL, CMD_MEM_WRI:   return SP_MEM;
         CMD_IO_RD, CMD_IO_WR:       return SP_IO;
         CMD_CFG_RD, CMD_CFG_WR:     return SP_CFG;
         default:                    return SP_NONE;
      endcase
   endfunction

   // Extra wait clocks after the decode clock before the claim drops.
   function automatic logic [1:0] claim_wait(input logic [1:0] spd);
      case (spd)
         2'd0:    return 2'd0;
         2'd1:    return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/tcd_addr_latch.sv
module tcd_addr_latch
   import tcd_pkg::*;
#(
   parameter int AD_W       = 32,
   parameter bit SUPPORT_64 = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap_lo,
   input  logic            cap_hi,
   input  logic [AD_W-1:0] ad,
   input  logic [3:0]      cbe_n,
   input  logic            idsel,
   input  logic [1:0]      speed_mode,
   output logic [AD_W-1:0] addr_lo,
   output logic [AD_W-1:0] addr_hi,
   output logic [3:0]      cmd,
   output logic            dual_q,
   output logic            idsel_q,
   output logic [1:0]      spd_q
);

   // Low half, command, slot select and speed: first address edge only.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_lo <= '0;
         cmd     <= '0;
         dual_q  <= 1'b0;
         idsel_q <= 1'b0;
         spd_q   <= '0;
      end else if (cap_lo) begin
         addr_lo <= ad;
         cmd     <= cbe_n;
         dual_q  <= (cbe_n == CMD_DUAL);
         idsel_q <= idsel;
         spd_q   <= speed_mode;
      end else if (cap_hi) begin
         cmd     <= cbe_n;
      end
   end

   // High half exists only in the 64-bit variant.
   generate
      if (SUPPORT_64) begin : g_hi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      addr_hi <= '0;
            else if (cap_lo) addr_hi <= '0;
            else if (cap_hi) addr_hi <= ad;
         end
      end else begin : g_nohi
         assign addr_hi = '0;
      end
   endgenerate

endmodule

// File: rtl/tcd_window_match.sv
module tcd_window_match
   import tcd_pkg::*;
#(
   parameter int AD_W  = 32,
   parameter int OFF_W = 12
) (
   input  logic [AD_W-1:0]   addr_lo,
   input  logic [AD_W-1:0]   addr_hi,
   input  logic [3:0]        cmd,
   input  logic              dual_q,
   input  logic              idsel_q,
   input  logic [2*AD_W-1:0] mem_base,
   input  logic [2*AD_W-1:0] mem_mask,
   input  logic [AD_W-1:0]   io_base,
   input  logic [AD_W-1:0]   io_mask,
   output logic              dec_hit,
   output logic [1:0]        dec_space,
   output logic [OFF_W-1:0]  dec_off
);

   localparam int WIDE_W = 2 * AD_W;

   space_e            cls;
   logic [WIDE_W-1:0] mem_diff;
   logic [AD_W-1:0]   io_diff;
   logic              mem_ok;
   logic              io_ok;

   assign mem_diff = ({addr_hi, addr_lo} ^ mem_base) & mem_mask;
   assign io_diff  = (addr_lo ^ io_base) & io_mask;
   assign mem_ok   = (mem_diff == '0);
   assign io_ok    = (io_diff == '0);

   always_comb begin
      cls     = cmd_space(cmd);
      dec_hit = 1'b0;
      dec_off = '0;
      case (cls)
         SP_MEM: begin
            dec_hit = mem_ok;
            dec_off = addr_lo[OFF_W-1:0] & ~mem_mask[OFF_W-1:0];
         end
         SP_IO: begin
            dec_hit = io_ok & ~dual_q;
            dec_off = addr_lo[OFF_W-1:0] & ~io_mask[OFF_W-1:0];
         end
         SP_CFG: begin
            dec_hit = idsel_q & ~dual_q;
            dec_off = addr_lo[OFF_W-1:0];
         end
         default: begin
            dec_hit = 1'b0;
         end
      endcase
      dec_space = dec_hit ? cls : SP_NONE;
   end

endmodule

// File: rtl/tcd_claim_fsm.sv
module tcd_claim_fsm
   import tcd_pkg::*;
#(
   parameter bit SUPPORT_64 = 1'b1,
   parameter int OFF_W      = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic             irdy_n,
   input  logic [3:0]       cbe_n,
   input  logic [1:0]       spd_q,
   input  logic             dec_hit,
   input  logic [1:0]       dec_space,
   input  logic [OFF_W-1:0] dec_off,
   output logic             cap_lo,
   output logic             cap_hi,
   output logic             dec_st,
   output logic             devsel_n,
   output logic             hit,
   output logic [1:0]       space,
   output logic [OFF_W-1:0] offset
);

   typedef enum logic [2:0] {
      ST_IDLE, ST_HI, ST_DEC, ST_WAIT, ST_CLAIM, ST_BUSY
   } st_e;

   st_e        st;
   st_e        dac_next;
   logic [1:0] cnt;
   logic [1:0] wait_n;
   logic       bus_idle;

   generate
      if (SUPPORT_64) begin : g_dac
         assign dac_next = ST_HI;
      end else begin : g_nodac
         assign dac_next = ST_BUSY;
      end
   endgenerate

   assign bus_idle = frame_n & irdy_n;
   assign wait_n   = claim_wait(spd_q);
   assign cap_lo   = (st == ST_IDLE) & ~frame_n;
   assign cap_hi   = (st == ST_HI);
   assign dec_st   = (st == ST_DEC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         devsel_n <= 1'b1;
         hit      <= 1'b0;
         space    <= SP_NONE;
         offset   <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (!frame_n) st <= (cbe_n == CMD_DUAL) ? dac_next : ST_DEC;
            end
            ST_HI: begin
               st <= bus_idle ? ST_IDLE : ST_DEC;
            end
            ST_DEC: begin
               if (bus_idle) begin
                  st <= ST_IDLE;
               end else if (dec_hit) begin
                  hit    <= 1'b1;
                  space  <= dec_space;
                  offset <= dec_off;
                  if (wait_n == 2'd0) begin
                     devsel_n <= 1'b0;
                     st       <= ST_CLAIM;
                  end else begin
                     cnt <= wait_n - 2'd1;
                     st  <= ST_WAIT;
                  end
               end else begin
                  st <= ST_BUSY;
               end
            end
            ST_WAIT: begin
               if (bus_idle) begin
                  st     <= ST_IDLE;
                  hit    <= 1'b0;
                  space  <= SP_NONE;
                  offset <= '0;
               end else if (cnt == 2'd0) begin
                  devsel_n <= 1'b0;
                  st       <= ST_CLAIM;
               end else begin
                  cnt <= cnt - 2'd1;
               end
            end
            ST_CLAIM: begin
               if (bus_idle) begin
                  st       <= ST_IDLE;
                  devsel_n <= 1'b1;
                  hit      <= 1'b0;
                  space    <= SP_NONE;
                  offset   <= '0;
               end
            end
            ST_BUSY: begin
               if (bus_idle) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tgt_claim_decoder.sv
module tgt_claim_decoder
   import tcd_pkg::*;
#(
   parameter int AD_W       = 32,
   parameter int OFF_W      = 12,
   parameter bit SUPPORT_64 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              irdy_n,
   input  logic [AD_W-1:0]   ad,
   input  logic [3:0]        cbe_n,
   input  logic              idsel,
   input  logic [1:0]        speed_mode,
   input  logic [2*AD_W-1:0] mem_base,
   input  logic [2*AD_W-1:0] mem_mask,
   input  logic [AD_W-1:0]   io_base,
   input  logic [AD_W-1:0]   io_mask,
   output logic              devsel_n,
   output logic              trdy_n,
   output logic              stop_n,
   output logic              hit,
   output logic [1:0]        space,
   output logic [OFF_W-1:0]  reg_offset
);

   generate
      if (AD_W < 16) begin : g_bad_ad
         $error("tgt_claim_decoder: AD_W must be at least 16");
      end
      if (OFF_W < 2 || OFF_W > AD_W) begin : g_bad_off
         $error("tgt_claim_decoder: OFF_W must lie in 2..AD_W");
      end
   endgenerate

   logic [AD_W-1:0]  addr_lo;
   logic [AD_W-1:0]  addr_hi;
   logic [3:0]       cmd;
   logic             dual_q;
   logic             idsel_q;
   logic [1:0]       spd_q;
   logic             cap_lo;
   logic             cap_hi;
   logic             dec_st;
   logic             dec_hit;
   logic [1:0]       dec_space;
   logic [OFF_W-1:0] dec_off;

   // Data-phase handshakes belong to another block: held deasserted.
   assign trdy_n = 1'b1;
   assign stop_n = 1'b1;

   tcd_addr_latch #(
      .AD_W       (AD_W),
      .SUPPORT_64 (SUPPORT_64)
   ) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_lo     (cap_lo),
      .cap_hi     (cap_hi),
      .ad         (ad),
      .cbe_n      (cbe_n),
      .idsel      (idsel),
      .speed_mode (speed_mode),
      .addr_lo    (addr_lo),
      .addr_hi    (addr_hi),
      .cmd        (cmd),
      .dual_q     (dual_q),
      .idsel_q    (idsel_q),
      .spd_q      (spd_q)
   );

   tcd_window_match #(
      .AD_W  (AD_W),
      .OFF_W (OFF_W)
   ) u_match (
      .addr_lo   (addr_lo),
      .addr_hi   (addr_hi),
      .cmd       (cmd),
      .dual_q    (dual_q),
      .idsel_q   (idsel_q),
      .mem_base  (mem_base),
      .mem_mask  (mem_mask),
      .io_base   (io_base),
      .io_mask   (io_mask),
      .dec_hit   (dec_hit),
      .dec_space (dec_space),
      .dec_off   (dec_off)
   );

   tcd_claim_fsm #(
      .SUPPORT_64 (SUPPORT_64),
      .OFF_W      (OFF_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_n   (frame_n),
      .irdy_n    (irdy_n),
      .cbe_n     (cbe_n),
      .spd_q     (spd_q),
      .dec_hit   (dec_hit),
      .dec_space (dec_space),
      .dec_off   (dec_off),
      .cap_lo    (cap_lo),
      .cap_hi    (cap_hi),
      .dec_st    (dec_st),
      .devsel_n  (devsel_n),
      .hit       (hit),
      .space     (space),
      .offset    (reg_offset)
   );

endmodule

// File: rtl/tgt_claim_decoder_chk.sv
module tgt_claim_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_n,
   input logic       irdy_n,
   input logic       devsel_n,
   input logic       hit,
   input logic [1:0] space,
   input logic       idsel_q,
   input logic [1:0] spd_q,
   input logic       dec_st
);

   logic [2:0] since_dec;
   logic [2:0] want_gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   since_dec <= '0;
      else if (dec_st)                              since_dec <= 3'd1;
      else if (since_dec != 3'd0 && since_dec != 3'd7) since_dec <= since_dec + 3'd1;
   end

   assign want_gap = (spd_q == 2'd0) ? 3'd1 : (spd_q == 2'd1) ? 3'd2 : 3'd3;

   // R2
   claim_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(devsel_n) |-> (since_dec == want_gap));

   // R2
   claim_has_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !devsel_n |-> hit);

   // R4
   cfg_needs_idsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!devsel_n && space == 2'd3) |-> idsel_q);

   // R5
   hit_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (space != 2'd0));

   // R9
   claim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!devsel_n && !(frame_n && irdy_n)) |=> !devsel_n);

   // R9
   claim_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_n && irdy_n) |=> (devsel_n && !hit));

endmodule

bind tgt_claim_decoder tgt_claim_decoder_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .frame_n  (frame_n),
   .irdy_n   (irdy_n),
   .devsel_n (devsel_n),
   .hit      (hit),
   .space    (space),
   .idsel_q  (idsel_q),
   .spd_q    (spd_q),
   .dec_st   (dec_st)
);

// File: tb/test_tgt_claim_decoder.sv
`timescale 1ns/1ps
module test_tgt_claim_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic        irdy_n = 1'b1;
   logic [31:0] ad = '0;
   logic [3:0]  cbe_n = 4'hF;
   logic        idsel = 1'b0;
   logic [1:0]  speed_mode = 2'd0;
   logic [63:0] mem_base = 64'h0000_0000_8000_0000;
   logic [63:0] mem_mask = 64'hFFFF_FFFF_FFF0_0000;
   logic [31:0] io_base  = 32'h0000_1000;
   logic [31:0] io_mask  = 32'hFFFF_FF00;
   logic        devsel_n, trdy_n, stop_n, hit;
   logic [1:0]  space;
   logic [11:0] reg_offset;
   logic        nd_devsel_n, nd_trdy_n, nd_stop_n, nd_hit;
   logic [1:0]  nd_space;
   logic [11:0] nd_offset;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   tgt_claim_decoder #(.AD_W(32), .OFF_W(12), .SUPPORT_64(1'b1)) i_tgt_claim_decoder (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
      .cbe_n(cbe_n), .idsel(idsel), .speed_mode(speed_mode),
      .mem_base(mem_base), .mem_mask(mem_mask), .io_base(io_base), .io_mask(io_mask),
      .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .hit(hit),
      .space(space), .reg_offset(reg_offset));

   tgt_claim_decoder #(.AD_W(32), .OFF_W(12), .SUPPORT_64(1'b0)) i_tgt_claim_decoder_nodac (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
      .cbe_n(cbe_n), .idsel(idsel), .speed_mode(speed_mode),
      .mem_base(mem_base), .mem_mask(mem_mask), .io_base(io_base), .io_mask(io_mask),
      .devsel_n(nd_devsel_n), .trdy_n(nd_trdy_n), .stop_n(nd_stop_n), .hit(nd_hit),
      .space(nd_space), .reg_offset(nd_offset));

   typedef struct packed {
      logic [3:0]  cmd;
      logic        dual;
      logic [31:0] lo;
      logic [31:0] hi;
      logic        mbh;
      logic        ids;
      logic [1:0]  spd;
      logic        ehit;
      logic [1:0]  esp;
      logic [11:0] eoff;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{4'h6, 1'b0, 32'h8001_2344, 32'h0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd1, 12'h344}, // R5 fast
      '{4'h7, 1'b0, 32'h800F_FFFC, 32'h0, 1'b0, 1'b0, 2'd1, 1'b1, 2'd1, 12'hFFC}, // R5 medium
      '{4'h6, 1'b0, 32'h9000_0000, 32'h0, 1'b0, 1'b0, 2'd2, 1'b0, 2'd0, 12'h000}, // R5 miss
      '{4'hE, 1'b0, 32'h8000_0010, 32'h0, 1'b0, 1'b0, 2'd3, 1'b1, 2'd1, 12'h010}, // R2 code 11
      '{4'h2, 1'b0, 32'h0000_10A4, 32'h0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd2, 12'h0A4}, // R6 hit
      '{4'h3, 1'b0, 32'h0000_2004, 32'h0, 1'b0, 1'b0, 2'd1, 1'b0, 2'd0, 12'h000}, // R6 miss
      '{4'h6, 1'b0, 32'h0000_10A4, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000}, // R7
      '{4'h2, 1'b0, 32'h8001_0000, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000}, // R7
      '{4'hA, 1'b0, 32'hABCD_E12C, 32'h0, 1'b0, 1'b1, 2'd0, 1'b1, 2'd3, 12'h12C}, // R4
      '{4'hB, 1'b0, 32'h0000_0010, 32'h0, 1'b0, 1'b0, 2'd1, 1'b0, 2'd0, 12'h000}, // R4 no select
      '{4'h0, 1'b0, 32'h8000_0000, 32'h0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 12'h000}, // R7 other
      '{4'h6, 1'b1, 32'h8000_0040, 32'h1, 1'b1, 1'b0, 2'd2, 1'b1, 2'd1, 12'h040}, // R8 hit
      '{4'h6, 1'b1, 32'h8000_0040, 32'h1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000}, // R8 miss
      '{4'h2, 1'b1, 32'h0000_10A4, 32'h1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000}  // R8 io
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic release_bus();
      frame_n = 1'b1;
      irdy_n  = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_vec(input vec_t v);
      int first;
      int exp_first;
      @(negedge clk);
      mem_base   = {31'b0, v.mbh, 32'h8000_0000};
      speed_mode = v.spd;
      idsel      = v.ids;
      frame_n    = 1'b0;
      ad         = v.lo;
      cbe_n      = v.dual ? 4'hD : v.cmd;
      if (v.dual) begin
         @(negedge clk);
         ad    = v.hi;
         cbe_n = v.cmd;
      end
      @(negedge clk);
      // R1: scramble everything captured; the decision must not move
      ad         = 32'hDEAD_BEEF;
      cbe_n      = 4'h0;
      idsel      = ~v.ids;
      speed_mode = 2'd0;
      first      = 0;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         if (!devsel_n && first == 0) first = k;
         if (k == 4) begin
            chk(hit == v.ehit, "R1 hit", 64'(hit), 64'(v.ehit));
            chk(space == v.esp, "R7 space", 64'(space), 64'(v.esp));
            if (v.ehit) chk(reg_offset == v.eoff, "R4 offset", 64'(reg_offset), 64'(v.eoff));
            chk(trdy_n && stop_n, "R3", {trdy_n, stop_n}, 64'h3);
            if (v.dual) chk(nd_devsel_n, "R8 no-64 claim", 64'(nd_devsel_n), 64'h1);
         end
      end
      exp_first = !v.ehit ? 0 : (v.spd == 2'd0) ? 1 : (v.spd == 2'd1) ? 2 : 3;
      chk(first == exp_first, "R2 claim edge", 64'(first), 64'(exp_first));
      release_bus();
      chk(devsel_n && !hit, "R9 release", {devsel_n, hit}, 64'h2);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(devsel_n && !hit && space == 2'd0, "R10 in reset", {devsel_n, hit, space}, 64'h8);
      rst_n = 1'b1;
      @(negedge clk);
      chk(devsel_n && !hit && space == 2'd0, "R10 after reset", {devsel_n, hit, space}, 64'h8);
      chk(trdy_n && stop_n, "R3 idle", {trdy_n, stop_n}, 64'h3);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R9 hold through last data phase, release only when both strobes high
      @(negedge clk);
      mem_base = 64'h0000_0000_8000_0000;
      speed_mode = 2'd0; frame_n = 1'b0; ad = 32'h8000_0100; cbe_n = 4'h6;
      @(negedge clk);
      ad = 32'h0; cbe_n = 4'h0; irdy_n = 1'b0;
      @(negedge clk);
      chk(!devsel_n, "R9 claimed", 64'(devsel_n), 64'h0);
      frame_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!devsel_n, "R9 hold", 64'(devsel_n), 64'h0);
      end
      irdy_n = 1'b1;
      @(negedge clk);
      chk(devsel_n && !hit, "R9 drop", {devsel_n, hit}, 64'h2);

      // R9 unclaimed cycle is not re-decoded while the frame stays low
      @(negedge clk);
      frame_n = 1'b0; ad = 32'h9000_0000; cbe_n = 4'h6;
      @(negedge clk);
      ad = 32'h8000_0000; cbe_n = 4'h6;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(devsel_n, "R9 busy no claim", 64'(devsel_n), 64'h1);
      end
      release_bus();
      run_vec(VECS[0]);

      // R10 reset in the middle of a claim
      @(negedge clk);
      frame_n = 1'b0; ad = 32'h8000_0200; cbe_n = 4'h7; speed_mode = 2'd0;
      @(negedge clk);
      ad = 32'h0;
      @(negedge clk);
      chk(!devsel_n, "R10 pre", 64'(devsel_n), 64'h0);
      rst_n = 1'b0;
      #1;
      chk(devsel_n && !hit && space == 2'd0, "R10 mid-claim", {devsel_n, hit, space}, 64'h8);
      frame_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule